// File: doc/BRIEF.md
# Pipeline Bundle Snooping Stage

This stage sits on a link of a multi-unit pipeline that carries typed command bundles, each a type code plus a data word. It passes the stream through one register slice with valid/ready handshaking on both sides. As each bundle goes by, the stage looks at its type. Types it owns update local configuration registers or fire an action pulse. Every other bundle moves on untouched.

The owned codes fall into three contiguous windows, each set by a base parameter and a count:
- single state registers;
- an indexed group that fills a register array, where entry k is written by code base+k;
- trigger codes, each reported as a one-cycle pulse with its index and data.

Every owned code has a slot number. Slots are numbered first over the single window, then the group window, then the trigger window. A drop-mask parameter with one bit per slot lets the stage consume an owned bundle that no later unit needs.

Top module: `bundle_snoop`

## Requirements
- R1: A bundle whose type lies outside all three owned windows appears at the output with the same type and data, in the order it was accepted.
- R2: No bundle is lost or duplicated under output backpressure. While the output is valid and not ready, its type and data hold steady.
- R3: Accepting a bundle with type SNG_BASE+i (i < NUM_SNG) loads register i of `cfg_o` (bits i*DATA_W upward) with its data. The new value is visible in the cycle after the accepting edge.
- R4: Accepting a bundle with type GRP_BASE+k (k < GRP_LEN) loads entry k of `grp_o` (bits k*DATA_W upward) with its data. The new value is visible in the cycle after acceptance.
- R5: Accepting a bundle with type TRG_BASE+j (j < NUM_TRG) raises `trig_o` for exactly the next cycle, with `trig_idx_o` = j and `trig_data_o` = the data.
- R6: An owned bundle whose slot bit in DROP_MASK is 1 is not forwarded, but its register update or trigger still takes place. Slot numbers are: i for single i, NUM_SNG+k for group entry k, and NUM_SNG+GRP_LEN+j for trigger j.
- R7: An owned bundle whose slot bit in DROP_MASK is 0 is forwarded unchanged, in addition to its register update or trigger.
- R8: After reset, all of `cfg_o` and `grp_o` read zero, and `out_valid_o` and `trig_o` are low.
- R9: `in_ready_o` is high whenever the output slice is empty or is draining in the same cycle. With `out_ready_i` held high, one bundle is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Upstream bundle valid |
| in_ready_o | output | 1 | Stage can accept a bundle |
| in_type_i | input | TYPE_W | Upstream bundle type |
| in_data_i | input | DATA_W | Upstream bundle data |
| out_valid_o | output | 1 | Downstream bundle valid |
| out_ready_i | input | 1 | Downstream can accept |
| out_type_o | output | TYPE_W | Downstream bundle type |
| out_data_o | output | DATA_W | Downstream bundle data |
| cfg_o | output | NUM_SNG*DATA_W | Single state registers, flattened |
| grp_o | output | GRP_LEN*DATA_W | Indexed group registers, flattened |
| trig_o | output | 1 | One-cycle action pulse |
| trig_idx_o | output | TRG_IDX_W | Index of the trigger within its window |
| trig_data_o | output | DATA_W | Data of the trigger bundle |

## Verification
The bench builds the stage with a 6-bit type field and a 32-bit data word. It uses two single registers at codes 4–5, a four-entry group at codes 8–11, and two triggers at codes 16–17. The drop mask is set on slots 1, 5 and 7, so each window contains both a dropped code and a forwarded code.

With only 64 type codes, every code is sent in each sweep. One sweep runs in ascending order with the output always ready. The other runs in descending order with pseudo-random backpressure and input gaps. Together they reach every window edge, every dropped and kept slot, and every stall pattern against the forwarding order.

// File: rtl/bundle_snoop_pkg.sv
package bundle_snoop_pkg;
  typedef enum logic [1:0] {
    K_PASS  = 2'd0,
    K_STATE = 2'd1,
    K_GROUP = 2'd2,
    K_TRIG  = 2'd3
  } kind_e;
endpackage

// File: rtl/bundle_snoop_decode.sv
module bundle_snoop_decode
  import bundle_snoop_pkg::*;
#(
  parameter int unsigned TYPE_W   = 9,
  parameter int unsigned SNG_BASE = 9'h050,
  parameter int unsigned NUM_SNG  = 4,
  parameter int unsigned GRP_BASE = 9'h100,
  parameter int unsigned GRP_LEN  = 16,
  parameter int unsigned TRG_BASE = 9'h1f8,
  parameter int unsigned NUM_TRG  = 8,
  parameter int unsigned SLOT_N   = NUM_SNG + GRP_LEN + NUM_TRG,
  parameter logic [SLOT_N-1:0] DROP_MASK = '0
) (
  input  logic [TYPE_W-1:0] type_i,
  output kind_e             kind_o,
  output logic [TYPE_W-1:0] off_o,
  output logic              drop_o
);
  localparam int unsigned SLOT_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1;

  logic [SLOT_W-1:0] slot;
  logic [31:0]       tv;

  always_comb begin
    tv     = 32'(type_i);
    kind_o = K_PASS;
    off_o  = '0;
    slot   = '0;
    if (tv >= SNG_BASE && tv < SNG_BASE + NUM_SNG) begin
      kind_o = K_STATE;
      off_o  = TYPE_W'(tv - SNG_BASE);
      slot   = SLOT_W'(tv - SNG_BASE);
    end else if (tv >= GRP_BASE && tv < GRP_BASE + GRP_LEN) begin
      kind_o = K_GROUP;
      off_o  = TYPE_W'(tv - GRP_BASE);
      slot   = SLOT_W'(NUM_SNG + (tv - GRP_BASE));
    end else if (tv >= TRG_BASE && tv < TRG_BASE + NUM_TRG) begin
      kind_o = K_TRIG;
      off_o  = TYPE_W'(tv - TRG_BASE);
      slot   = SLOT_W'(NUM_SNG + GRP_LEN + (tv - TRG_BASE));
    end
    drop_o = (kind_o != K_PASS) && DROP_MASK[slot];
  end
endmodule

// File: rtl/bundle_snoop_fwd.sv
module bundle_snoop_fwd #(
  parameter int unsigned TYPE_W = 9,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [TYPE_W-1:0] in_type_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              drop_i,
  output logic              acc_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [TYPE_W-1:0] out_type_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic              vld_q;
  logic [TYPE_W-1:0] type_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready_o  = !vld_q || out_ready_i;
  assign acc_o       = in_valid_i && in_ready_o;
  assign out_valid_o = vld_q;
  assign out_type_o  = type_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      type_q <= '0;
      data_q <= '0;
    end else begin
      if (in_ready_o) vld_q <= acc_o && !drop_i;
      if (acc_o && !drop_i) begin
        type_q <= in_type_i;
        data_q <= in_data_i;
      end
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_type_o) && $stable(out_data_o));

  // R6
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o && drop_i |=> !out_valid_o);

  // R7
  fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o && !drop_i |=> out_valid_o && out_data_o == $past(in_data_i)
                         && out_type_o == $past(in_type_i));
endmodule

// File: rtl/bundle_snoop_regs.sv
module bundle_snoop_regs
  import bundle_snoop_pkg::*;
#(
  parameter int unsigned TYPE_W  = 9,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SNG = 4,
  parameter int unsigned GRP_LEN = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        acc_i,
  input  kind_e                       kind_i,
  input  logic [TYPE_W-1:0]           off_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic [NUM_SNG*DATA_W-1:0]   cfg_o,
  output logic [GRP_LEN*DATA_W-1:0]   grp_o
);
  for (genvar i = 0; i < NUM_SNG; i++) begin : g_sng
    logic [DATA_W-1:0] r_q;
    logic              we;
    assign we = acc_i && kind_i == K_STATE && 32'(off_i) == i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  r_q <= '0;
      else if (we)  r_q <= data_i;
    end
    assign cfg_o[i*DATA_W +: DATA_W] = r_q;
  end

  for (genvar k = 0; k < GRP_LEN; k++) begin : g_grp
    logic [DATA_W-1:0] r_q;
    logic              we;
    assign we = acc_i && kind_i == K_GROUP && 32'(off_i) == k;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  r_q <= '0;
      else if (we)  r_q <= data_i;
    end
    assign grp_o[k*DATA_W +: DATA_W] = r_q;
  end

  // R3
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(cfg_o) && $stable(grp_o));
endmodule

// File: rtl/bundle_snoop.sv
module bundle_snoop
  import bundle_snoop_pkg::*;
#(
  parameter int unsigned TYPE_W    = 9,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SNG_BASE  = 9'h050,
  parameter int unsigned NUM_SNG   = 4,
  parameter int unsigned GRP_BASE  = 9'h100,
  parameter int unsigned GRP_LEN   = 16,
  parameter int unsigned TRG_BASE  = 9'h1f8,
  parameter int unsigned NUM_TRG   = 8,
  parameter logic [NUM_SNG+GRP_LEN+NUM_TRG-1:0] DROP_MASK = '0,
  parameter int unsigned TRG_IDX_W = (NUM_TRG > 1) ? $clog2(NUM_TRG) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [TYPE_W-1:0]         in_type_i,
  input  logic [DATA_W-1:0]         in_data_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [TYPE_W-1:0]         out_type_o,
  output logic [DATA_W-1:0]         out_data_o,
  output logic [NUM_SNG*DATA_W-1:0] cfg_o,
  output logic [GRP_LEN*DATA_W-1:0] grp_o,
  output logic                      trig_o,
  output logic [TRG_IDX_W-1:0]      trig_idx_o,
  output logic [DATA_W-1:0]         trig_data_o
);
  localparam int unsigned SLOT_N = NUM_SNG + GRP_LEN + NUM_TRG;

  kind_e             kind;
  logic [TYPE_W-1:0] off;
  logic              drop;
  logic              acc;

  bundle_snoop_decode #(
    .TYPE_W(TYPE_W), .SNG_BASE(SNG_BASE), .NUM_SNG(NUM_SNG),
    .GRP_BASE(GRP_BASE), .GRP_LEN(GRP_LEN), .TRG_BASE(TRG_BASE),
    .NUM_TRG(NUM_TRG), .SLOT_N(SLOT_N), .DROP_MASK(DROP_MASK)
  ) u_dec (
    .type_i(in_type_i), .kind_o(kind), .off_o(off), .drop_o(drop)
  );

  bundle_snoop_fwd #(.TYPE_W(TYPE_W), .DATA_W(DATA_W)) u_fwd (
    .clk_i, .rst_ni,
    .in_valid_i, .in_ready_o, .in_type_i, .in_data_i,
    .drop_i(drop), .acc_o(acc),
    .out_valid_o, .out_ready_i, .out_type_o, .out_data_o
  );

  bundle_snoop_regs #(
    .TYPE_W(TYPE_W), .DATA_W(DATA_W), .NUM_SNG(NUM_SNG), .GRP_LEN(GRP_LEN)
  ) u_regs (
    .clk_i, .rst_ni, .acc_i(acc), .kind_i(kind), .off_i(off),
    .data_i(in_data_i), .cfg_o, .grp_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o      <= 1'b0;
      trig_idx_o  <= '0;
      trig_data_o <= '0;
    end else begin
      trig_o <= acc && kind == K_TRIG;
      if (acc && kind == K_TRIG) begin
        trig_idx_o  <= TRG_IDX_W'(off);
        trig_data_o <= in_data_i;
      end
    end
  end

  // R5
  trig_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(in_valid_i && in_ready_o));
endmodule

// File: tb/sim_bundle_snoop.sv
module sim_bundle_snoop;
  localparam int CLK_P = 10;
  localparam int TW = 6, DW = 32;
  localparam int SB = 4, NS = 2, GB = 8, GL = 4, TB = 16, NT = 2;
  localparam logic [7:0] DMASK = 8'b1010_0010;

  logic clk_i = 0, rst_ni = 0;
  logic in_valid_i = 0, in_ready_o, out_valid_o, out_ready_i = 1;
  logic [TW-1:0] in_type_i = '0, out_type_o;
  logic [DW-1:0] in_data_i = '0, out_data_o, trig_data_o;
  logic [NS*DW-1:0] cfg_o;
  logic [GL*DW-1:0] grp_o;
  logic trig_o;
  logic [0:0] trig_idx_o;

  bundle_snoop #(.TYPE_W(TW), .DATA_W(DW), .SNG_BASE(SB), .NUM_SNG(NS),
    .GRP_BASE(GB), .GRP_LEN(GL), .TRG_BASE(TB), .NUM_TRG(NT),
    .DROP_MASK(DMASK)) u0 (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int total = 0, bad = 0, n_out = 0, stalls = 0;
  bit bp_on = 0, done = 0;
  logic [7:0] lfsr = 8'h5a;
  logic [TW-1:0] q_t[$];
  logic [DW-1:0] q_d[$];
  int            q_ti[$];
  logic [DW-1:0] q_td[$];
  logic [DW-1:0] m_cfg[NS];
  logic [DW-1:0] m_grp[GL];
  bit prev_stall = 0;
  logic [TW-1:0] prev_t;
  logic [DW-1:0] prev_d;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int kind_of(input int t);
    if (t >= SB && t < SB+NS) return 1;
    if (t >= GB && t < GB+GL) return 2;
    if (t >= TB && t < TB+NT) return 3;
    return 0;
  endfunction

  function automatic int slot_of(input int t);
    case (kind_of(t))
      1: return t - SB;
      2: return NS + t - GB;
      3: return NS + GL + t - TB;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk_i) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready_i <= bp_on ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  always @(negedge clk_i) begin
    #2;
    if (rst_ni && !done) begin
      if (prev_stall)
        chk(out_valid_o && out_type_o == prev_t && out_data_o == prev_d, "R2",
            {out_type_o, out_data_o}, {prev_t, prev_d});
      prev_stall = out_valid_o && !out_ready_i;
      prev_t = out_type_o; prev_d = out_data_o;
      if (out_valid_o && out_ready_i) begin
        n_out++;
        if (q_t.size() == 0) chk(0, "R2", 64'(out_type_o), 64'hffff);
        else begin
          logic [TW-1:0] et;
          logic [DW-1:0] ed;
          et = q_t.pop_front(); ed = q_d.pop_front();
          chk(out_type_o == et && out_data_o == ed, kind_of(int'(et)) == 0 ? "R1" : "R7",
              {out_type_o, out_data_o}, {et, ed});
        end
      end
      if (trig_o) begin
        if (q_ti.size() == 0) chk(0, "R5", 64'(trig_idx_o), 64'hffff);
        else begin
          int ei;
          logic [DW-1:0] ed;
          ei = q_ti.pop_front(); ed = q_td.pop_front();
          chk(int'(trig_idx_o) == ei && trig_data_o == ed, "R5",
              {trig_idx_o, trig_data_o}, {ei[0], ed});
        end
      end
    end
  end

  // enter and leave at a negedge
  task automatic send(input int t, input logic [DW-1:0] d);
    in_valid_i = 1; in_type_i = TW'(t); in_data_i = d;
    forever begin
      #1;
      if (in_ready_o) begin
        int k;
        k = kind_of(t);
        if (k == 1) m_cfg[t-SB] = d;
        if (k == 2) m_grp[t-GB] = d;
        if (k == 3) begin q_ti.push_back(t-TB); q_td.push_back(d); end
        if (k == 0 || !DMASK[slot_of(t)]) begin q_t.push_back(TW'(t)); q_d.push_back(d); end
        @(negedge clk_i);
        break;
      end
      stalls++;
      @(negedge clk_i);
    end
    in_valid_i = 0;
  endtask

  task automatic drain_and_check(input int exp_out);
    repeat (30) @(negedge clk_i);
    #3;
    chk(q_t.size() == 0 && q_ti.size() == 0, "R2", 64'(q_t.size()), 0);
    // 64 codes minus 3 dropped slots
    chk(n_out == exp_out, "R6", 64'(n_out), 64'(exp_out));
    for (int i = 0; i < NS; i++)
      chk(cfg_o[i*DW +: DW] == m_cfg[i], "R3", 64'(cfg_o[i*DW +: DW]), 64'(m_cfg[i]));
    for (int k = 0; k < GL; k++)
      chk(grp_o[k*DW +: DW] == m_grp[k], "R4", 64'(grp_o[k*DW +: DW]), 64'(m_grp[k]));
  endtask

  function automatic logic [DW-1:0] mk(input int p, input int t);
    return {8'(p), 8'(t), 16'(t*37 + p*101 + 5)};
  endfunction

  initial begin
    for (int i = 0; i < NS; i++) m_cfg[i] = '0;
    for (int k = 0; k < GL; k++) m_grp[k] = '0;
    repeat (3) @(negedge clk_i);
    #3;
    // R8
    chk(cfg_o == '0 && grp_o == '0, "R8", 64'(cfg_o), 0);
    chk(!out_valid_o && !trig_o, "R8", {out_valid_o, trig_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(in_ready_o, "R9", 64'(in_ready_o), 1);

    // R3 visibility timing
    in_valid_i = 1; in_type_i = TW'(SB+1); in_data_i = 32'hcafe_0001;
    #1;
    chk(cfg_o[DW +: DW] == '0, "R3", 64'(cfg_o[DW +: DW]), 0);
    in_valid_i = 0;
    send(SB+1, 32'hcafe_0001);
    #3;
    chk(cfg_o[DW +: DW] == 32'hcafe_0001, "R3", 64'(cfg_o[DW +: DW]), 64'hcafe0001);
    @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    n_out = 0;

    // sweep 1: ascending, no backpressure
    stalls = 0;
    for (int t = 0; t < 64; t++) send(t, mk(1, t));
    chk(stalls == 0, "R9", 64'(stalls), 0);
    drain_and_check(61);

    // sweep 2: descending, backpressure, gaps
    n_out = 0;
    bp_on = 1;
    for (int i = 0; i < 64; i++) begin
      send(63 - i, mk(2, 63 - i));
      if (i % 5 == 4) @(negedge clk_i);
    end
    bp_on = 0;
    drain_and_check(61);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule